// File: doc/BRIEF.md
# Switch Monitor Serial Command and Status Port

This block is the serial front end of a twelve-channel switch monitor. It acts as a 16-bit full-duplex serial slave: while chip select is low it shifts a status word out on its data output, most significant bit first, and shifts a command word in. The status word is a snapshot taken when chip select falls. It holds the operating mode reported by the mode controller, the master/slave strap, the interrupt flag and the twelve switch states. The command word is decoded only when chip select rises, and only if exactly sixteen clocks were seen. So each reply shows the state before the command that travels with it.

The block keeps the configuration that the rest of the monitor uses. This is a run register (mode, off-time code, wakeup code and polarity of the four programmable channels), a twelve-bit tristate mask and a twelve-bit metallic mask. It raises one-cycle strobes for the run, sleep and test commands so the mode controller can act on them. It also holds the active-low interrupt line. An event pulse from the mode controller pulls the line low, and the next chip-select rising edge releases it. The serial pins are sampled by a fast system clock through synchronizers and edge detectors.

All pins are plain levels. Neither side of the serial link can apply back-pressure: the host owns the serial clock, and the block keeps up at any rate below a quarter of the system clock.

Top module: `switch_spi_responder`

## Requirements
- R1: After reset, `miso_oe` is 0, `int_n` is 1, and `cfg_tri`, `cfg_metal`, `cfg_mode`, `cfg_off`, `cfg_wake` and `cfg_pol` are all zero.
- R2: The reply is shifted out MSB first. A new bit appears after each falling serial clock. The reply bits are: [15:14] = `mode_now`, [13] = `ms_sel`, [12] = interrupt flag, [11:0] = reported switch states, using the same bit order as `sw_closed` (ground channels 6..1, then programmable 4..1, then battery 2..1). All values are sampled at the chip-select falling edge, and later changes do not alter that reply.
- R3: A command whose top nibble is 0001 (run) loads `cfg_mode` from bits [11:10], `cfg_off` from [9:7], `cfg_wake` from [5:4] and `cfg_pol` from [3:0]. Bit 6 is ignored. `go_run` pulses for one cycle.
- R4: Top nibble 0011 loads bits [11:0] into `cfg_tri`. Top nibble 0101 loads bits [11:0] into `cfg_metal`. Neither command pulses any strobe.
- R5: Top nibble 0000 pulses `go_sleep` and changes no register. At most one strobe is high in any cycle.
- R6: A command with bit 15 set pulses `go_test` and changes no register.
- R7: Top nibbles 0010, 0100, 0110 and 0111 change no register and pulse no strobe.
- R8: A frame with fewer or more than 16 rising serial clocks changes no register and pulses no strobe.
- R9: A one-cycle `irq_event` drives `int_n` low on the next cycle. `int_n` stays low until a chip-select rising edge, which releases it unless a new event arrives in that same cycle. The reply bit [12] equals the inverse of `int_n` at the chip-select falling edge.
- R10: A channel whose `cfg_tri` bit is 1 is reported as 0. While `mode_now` is 00 (sleep), all twelve switch bits are reported as 0.
- R11: `miso_oe` is 1 only while the synchronized chip select is low.
- R12: The configuration outputs do not change while a frame is in progress. A command takes effect only after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial command data into the block |
| miso | output | 1 | Serial reply data out of the block |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |
| ms_sel | input | 1 | Master/slave strap level |
| mode_now | input | 2 | Operating mode reported by the mode controller |
| sw_closed | input | 12 | Switch states from the input channels, 1 = closed |
| irq_event | input | 1 | One-cycle interrupt request from the mode controller |
| int_n | output | 1 | Active-low interrupt line (open-drain behaviour) |
| cfg_mode | output | 2 | Requested operating mode from the last run command |
| cfg_off | output | 3 | Polling off-time code |
| cfg_wake | output | 2 | Wakeup interval code |
| cfg_pol | output | 4 | Programmable channel polarity, 1 = switch to battery |
| cfg_tri | output | 12 | Per-channel tristate mask |
| cfg_metal | output | 12 | Per-channel metallic mask |
| go_run | output | 1 | One-cycle strobe for an accepted run command |
| go_sleep | output | 1 | One-cycle strobe for an accepted sleep command |
| go_test | output | 1 | One-cycle strobe for an accepted test-mode command |

## Verification
A table of frames walks every command opcode, including each ignored nibble. Each frame uses a different switch pattern, mode and strap level. Because of this, a wrong field position in the reply, a missing tristate or sleep mask, or a reply that already reflects the new command each gives a visibly different word. Directed frames then cover the remaining cases:
- frames of 15 and 17 clocks, which must leave the registers untouched;
- a switch change after chip select falls, which separates a snapshot from a live read;
- a check before chip select rises, which separates an early apply from a late one;
- interrupt events raised before and during a frame, which separate the flag latched at the falling edge from the clear at the rising edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CH_COUNT   = 12;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 2;

  typedef enum logic [3:0] {
    OP_SLEEP = 4'b0000,
    OP_RUN   = 4'b0001,
    OP_TRI   = 4'b0011,
    OP_METAL = 4'b0101
  } opcode_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] off;
    logic [1:0] wake;
    logic [3:0] pol;
  } run_cfg_t;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_s,
  input  logic                  sclk_s,
  input  logic                  mosi_s,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic                  miso,
  output logic                  miso_oe,
  output logic                  frame_end,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] rx_word
);
  logic                  cs_d, sck_d;
  logic [FRAME_BITS-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  cs_fall, sck_rise, sck_fall;

  assign cs_fall   = cs_d & ~cs_s;
  assign frame_end = ~cs_d & cs_s;
  assign sck_rise  = ~sck_d & sclk_s & ~cs_s;
  assign sck_fall  = sck_d & ~sclk_s & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sclk_s;
      if (cs_fall) begin
        tx_q  <= load_word;
        rx_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (sck_rise) begin
          rx_q <= {rx_q[FRAME_BITS-2:0], mosi_s};
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_fall) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign miso     = tx_q[FRAME_BITS-1];
  assign miso_oe  = ~cs_d;
  assign frame_ok = frame_end && (cnt_q == CNT_W'(FRAME_BITS));
  assign rx_word  = rx_q;

  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !miso_oe); // R11
  AST_OE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> miso_oe); // R11
  AST_LOAD_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (miso == $past(load_word[FRAME_BITS-1]))); // R2
endmodule

// File: rtl/ssr_cfg.sv
module ssr_cfg
  import ssr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic [FRAME_BITS-1:0] word,
  output run_cfg_t              run_q,
  output logic [CH_COUNT-1:0]   tri_q,
  output logic [CH_COUNT-1:0]   metal_q,
  output logic                  go_run,
  output logic                  go_sleep,
  output logic                  go_test
);
  logic [3:0] op;
  logic       is_test, is_run, is_sleep, is_tri, is_metal;
  logic       unused_spare;

  assign op           = word[FRAME_BITS-1 -: 4];
  assign unused_spare = word[6];
  assign is_test      = op[3];
  assign is_run       = (op == OP_RUN);
  assign is_sleep     = (op == OP_SLEEP);
  assign is_tri       = (op == OP_TRI);
  assign is_metal     = (op == OP_METAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      tri_q    <= '0;
      metal_q  <= '0;
      go_run   <= 1'b0;
      go_sleep <= 1'b0;
      go_test  <= 1'b0;
    end else begin
      go_run   <= apply & is_run;
      go_sleep <= apply & is_sleep;
      go_test  <= apply & is_test;
      if (apply && is_run) begin
        run_q.mode <= word[11:10];
        run_q.off  <= word[9:7];
        run_q.wake <= word[5:4];
        run_q.pol  <= word[3:0];
      end
      if (apply && is_tri)   tri_q   <= word[CH_COUNT-1:0];
      if (apply && is_metal) metal_q <= word[CH_COUNT-1:0];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(run_q) && $stable(tri_q) && $stable(metal_q))); // R12
  AST_TEST_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && word[15]) |=> ($stable(run_q) && $stable(tri_q) && $stable(metal_q))); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_run, go_sleep, go_test})); // R5
endmodule

// File: rtl/ssr_irq.sv
module ssr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_event,
  input  logic cs_rise,
  output logic flag,
  output logic int_n
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (irq_event) flag_q <= 1'b1;
    else if (cs_rise)   flag_q <= 1'b0;
  end

  assign flag  = flag_q;
  assign int_n = ~flag_q;

  AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> !int_n); // R9
  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !irq_event) |=> int_n); // R9
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !cs_rise) |=> !int_n); // R9
endmodule

// File: rtl/switch_spi_responder.sv
module switch_spi_responder
  import ssr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  output logic        miso,
  output logic        miso_oe,
  input  logic        ms_sel,
  input  logic [1:0]  mode_now,
  input  logic [11:0] sw_closed,
  input  logic        irq_event,
  output logic        int_n,
  output logic [1:0]  cfg_mode,
  output logic [2:0]  cfg_off,
  output logic [1:0]  cfg_wake,
  output logic [3:0]  cfg_pol,
  output logic [11:0] cfg_tri,
  output logic [11:0] cfg_metal,
  output logic        go_run,
  output logic        go_sleep,
  output logic        go_test
);
  logic [2:0]            pins_s;
  logic                  frame_end, frame_ok, int_flag, sleeping;
  logic [FRAME_BITS-1:0] rx_word, status_word;
  logic [CH_COUNT-1:0]   sw_rep, tri_q;
  run_cfg_t              run_q;

  ssr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, mosi}), .q(pins_s));

  assign sleeping = (mode_now == 2'b00);

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_rep
    assign sw_rep[ch] = ~sleeping & sw_closed[ch] & ~tri_q[ch];
  end

  assign status_word = {mode_now, ms_sel, int_flag, sw_rep};

  ssr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
    .load_word(status_word), .miso(miso), .miso_oe(miso_oe),
    .frame_end(frame_end), .frame_ok(frame_ok), .rx_word(rx_word));

  ssr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .apply(frame_ok), .word(rx_word),
    .run_q(run_q), .tri_q(tri_q), .metal_q(cfg_metal),
    .go_run(go_run), .go_sleep(go_sleep), .go_test(go_test));

  ssr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_event(irq_event), .cs_rise(frame_end),
    .flag(int_flag), .int_n(int_n));

  assign cfg_mode = run_q.mode;
  assign cfg_off  = run_q.off;
  assign cfg_wake = run_q.wake;
  assign cfg_pol  = run_q.pol;
  assign cfg_tri  = tri_q;

  AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> ($stable(cfg_tri) && $stable(cfg_metal) && $stable(run_q))); // R8
  AST_NO_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pins_s[2]) && pins_s[2]) |-> !miso_oe); // R11
endmodule

// File: tb/switch_spi_responder_test.sv
module switch_spi_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic        miso, miso_oe, ms_sel = 1'b0, irq_event = 1'b0, int_n;
  logic [1:0]  mode_now = 2'b00;
  logic [11:0] sw_closed = '0;
  logic [1:0]  cfg_mode, cfg_wake;
  logic [2:0]  cfg_off;
  logic [3:0]  cfg_pol;
  logic [11:0] cfg_tri, cfg_metal;
  logic        go_run, go_sleep, go_test;

  int total = 0, bad = 0, n_run = 0, n_sleep = 0, n_test = 0;
  bit finished = 0;

  logic [11:0] m_run = '0, m_tri = '0, m_metal = '0;

  always #5 clk = ~clk;

  switch_spi_responder uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .ms_sel(ms_sel), .mode_now(mode_now),
    .sw_closed(sw_closed), .irq_event(irq_event), .int_n(int_n),
    .cfg_mode(cfg_mode), .cfg_off(cfg_off), .cfg_wake(cfg_wake), .cfg_pol(cfg_pol),
    .cfg_tri(cfg_tri), .cfg_metal(cfg_metal),
    .go_run(go_run), .go_sleep(go_sleep), .go_test(go_test));

  always @(posedge clk) begin
    if (go_run)   n_run++;
    if (go_sleep) n_sleep++;
    if (go_test)  n_test++;
  end

  typedef struct packed {
    logic [15:0] cmd;
    logic [11:0] sw;
    logic [1:0]  md;
    logic        ms;
    logic [15:0] resp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'h16AA, 12'hA5C, 2'b00, 1'b0, 16'h0000},
    '{16'h3F00, 12'hFFF, 2'b01, 1'b1, 16'h6FFF},
    '{16'h5123, 12'hFFF, 2'b10, 1'b0, 16'h80FF},
    '{16'h2FFF, 12'h3C3, 2'b11, 1'b1, 16'hE0C3},
    '{16'h4ABC, 12'h800, 2'b01, 1'b0, 16'h4000},
    '{16'h3000, 12'hF0F, 2'b01, 1'b0, 16'h400F},
    '{16'h6123, 12'h5A5, 2'b01, 1'b1, 16'h65A5},
    '{16'h7777, 12'h001, 2'b10, 1'b0, 16'h8001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_open();
    cs_n = 1'b0;
    ticks(8);
  endtask

  task automatic spi_bits(input logic [15:0] w, input int n, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      ticks(4);
      r = {r[14:0], miso};
      sclk = 1'b1;
      ticks(4);
      sclk = 1'b0;
    end
    ticks(4);
  endtask

  task automatic spi_close();
    cs_n = 1'b1;
    ticks(6);
  endtask

  task automatic frame(input logic [15:0] w, input int n, output logic [15:0] r);
    spi_open();
    spi_bits(w, n, r);
    spi_close();
  endtask

  task automatic model_apply(input logic [15:0] w);
    if (w[15]) ;
    else if (w[15:12] == 4'b0001) m_run = w[11:0];
    else if (w[15:12] == 4'b0011) m_tri = w[11:0];
    else if (w[15:12] == 4'b0101) m_metal = w[11:0];
  endtask

  task automatic check_cfg(input string req);
    check(req, {20'd0, cfg_tri}, {20'd0, m_tri});
    check(req, {20'd0, cfg_metal}, {20'd0, m_metal});
    check(req, {21'd0, cfg_mode, cfg_off, cfg_wake, cfg_pol},
          {21'd0, m_run[11:10], m_run[9:7], m_run[5:4], m_run[3:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int pr, ps, pt;
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    // R1 reset state
    check("R1 oe", {31'd0, miso_oe}, 0);
    check("R1 int_n", {31'd0, int_n}, 1);
    check_cfg("R1 cfg");

    // table walk: R2 R3 R4 R5 R7 R10
    foreach (VEC[k]) begin
      sw_closed = VEC[k].sw;
      mode_now  = VEC[k].md;
      ms_sel    = VEC[k].ms;
      pr = n_run; ps = n_sleep; pt = n_test;
      frame(VEC[k].cmd, 16, r);
      check("R2 R10 reply", {16'd0, r}, {16'd0, VEC[k].resp});
      model_apply(VEC[k].cmd);
      check_cfg("R3 R4 R7 cfg");
      check("R3 R7 go_run", n_run - pr, (VEC[k].cmd[15:12] == 4'b0001) ? 1 : 0);
      check("R4 R7 strobes", (n_sleep - ps) + (n_test - pt), 0);
    end

    // R11 output enable follows chip select
    check("R11 idle oe", {31'd0, miso_oe}, 0);
    spi_open();
    check("R11 open oe", {31'd0, miso_oe}, 1);
    spi_bits(16'h2000, 16, r);
    spi_close();
    check("R11 closed oe", {31'd0, miso_oe}, 0);

    // R2 snapshot at chip-select fall
    mode_now = 2'b01; ms_sel = 1'b0; sw_closed = 12'h0F0;
    spi_open();
    sw_closed = 12'hFFF;
    spi_bits(16'h2000, 16, r);
    spi_close();
    check("R2 snapshot", {16'd0, r}, 32'h40F0);

    // R12 command waits for chip-select rise
    spi_open();
    spi_bits(16'h3ABC, 16, r);
    check("R12 before rise", {20'd0, cfg_tri}, {20'd0, m_tri});
    spi_close();
    m_tri = 12'hABC;
    check("R12 after rise", {20'd0, cfg_tri}, 32'hABC);
    frame(16'h3000, 16, r);
    m_tri = '0;

    // R8 short and long frames discarded
    pr = n_run;
    frame(16'h3555, 15, r);
    check_cfg("R8 short");
    frame(16'h3555, 17, r);
    check_cfg("R8 long");
    frame(16'h1FFF, 15, r);
    check("R8 no run", n_run - pr, 0);
    check_cfg("R8 run short");

    // R5 sleep and R6 test
    ps = n_sleep; pt = n_test;
    frame(16'h0FFF, 16, r);
    check("R5 sleep strobe", n_sleep - ps, 1);
    check_cfg("R5 sleep cfg");
    frame(16'h8FFF, 16, r);
    check("R6 test strobe", n_test - pt, 1);
    check_cfg("R6 test cfg");

    // R9 interrupt
    sw_closed = 12'h000; mode_now = 2'b01; ms_sel = 1'b0;
    irq_event = 1'b1; ticks(1); irq_event = 1'b0;
    check("R9 low", {31'd0, int_n}, 0);
    ticks(20);
    check("R9 sticky", {31'd0, int_n}, 0);
    frame(16'h2000, 16, r);
    check("R9 flag bit", {16'd0, r}, 32'h5000);
    check("R9 released", {31'd0, int_n}, 1);
    spi_open();
    irq_event = 1'b1; ticks(1); irq_event = 1'b0;
    spi_bits(16'h2000, 16, r);
    check("R9 low in frame", {31'd0, int_n}, 0);
    spi_close();
    check("R9 prior flag", {16'd0, r}, 32'h4000);
    check("R9 cleared", {31'd0, int_n}, 1);

    // R10 tristated channel reads open
    frame(16'h3801, 16, r);
    sw_closed = 12'hFFF;
    frame(16'h3000, 16, r);
    check("R10 tri mask", {16'd0, r}, 32'h47FE);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule